// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

This block watches the running time of a calendar counter (BCD minute, BCD hour and a weekday code) and raises a level interrupt when that time enters an alarm setting. The alarm is a BCD minute, a BCD hour and a seven-bit set of allowed weekdays. Because the day is picked by a mask rather than a date, one setting can repeat on several days of the week, and no alarm can lie more than one week ahead. Seconds are never compared, so the resolution is one minute.

Software programs the alarm through a small write port. The interrupt is raised once, on the cycle in which the time first matches. It is not raised again until the time has left the match and come back. The pending flag stays set until software writes a one to the clear bit. An enable bit gates both the raising of the flag and the visible interrupt line.

A two-state machine tracks the match. In ARMED the block waits for a match. The transition ARM_TO_HELD is taken when the match appears, and the flag is set in that transition if the alarm is enabled. In HELD the block waits for the match to end. The transition HELD_TO_ARMED is taken as soon as the match drops.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset the interrupt is low, the alarm is disabled, the weekday mask is zero and the machine is in ARMED.
- R2: A match needs the current BCD minute to equal the alarm minute (address 0) and the current BCD hour to equal the alarm hour (address 1), compared as 8-bit codes. A difference in either field prevents the interrupt.
- R3: Bit n of the weekday mask (address 2, data bits 6:0) allows weekday code n for n from 0 to 6. A weekday code of 7 never matches.
- R4: Only one trigger occurs per matching interval. Once the flag has been cleared while the time still matches, the flag stays low for the rest of that interval.
- R5: When the match ends, the block re-arms. A later entry into the match raises the flag again, and this includes an entry caused by a write to an alarm register.
- R6: The flag is set only if the enable bit (address 3, data bit 4) is 1 on the cycle the match begins. Setting the enable later in the same interval raises nothing.
- R7: The interrupt output is the pending flag gated by the enable bit. Writing 0 to address 3 hides a pending flag without losing it, and setting the enable again shows it.
- R8: A write to address 3 with data bit 0 set clears the pending flag. A write with bit 0 clear leaves the flag unchanged.
- R9: If a clear write and a new match entry fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 minute, 1 hour, 2 weekday mask, 3 control |
| cfg_wdata | input | 8 | Write data |
| cur_min | input | 8 | Current BCD minute |
| cur_hour | input | 8 | Current BCD hour |
| cur_wday | input | 3 | Current weekday code, 0 to 6 |
| alarm_irq | output | 1 | Level interrupt: pending flag gated by the enable bit |

## Verification
The bench builds the block with its default parameters: seven weekdays, 8-bit BCD fields and the enable bit at position 4. Because these are small, all 128 weekday masks can be crossed with all eight weekday codes, including the invalid code 7. Every legal BCD minute and hour is also swept against a fixed alarm. Sequences around a single match interval cover re-arming, enable timing, hiding a pending flag, and a clear that coincides with a new match.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } alarm_state_e;

    localparam logic [1:0] ADDR_MIN  = 2'd0;
    localparam logic [1:0] ADDR_HOUR = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs #(
    parameter int DAYS    = 7,
    parameter int FIELD_W = 8,
    parameter int EN_BIT  = 4,
    parameter int CLR_BIT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [FIELD_W-1:0] wdata,
    output logic [FIELD_W-1:0] alm_min,
    output logic [FIELD_W-1:0] alm_hour,
    output logic [DAYS-1:0]    alm_mask,
    output logic               alm_en,
    output logic               clr_pulse
);
    import rtc_alarm_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_min  <= '0;
            alm_hour <= '0;
            alm_mask <= '0;
            alm_en   <= 1'b0;
        end else if (we) begin
            unique case (addr)
                ADDR_MIN:  alm_min  <= wdata;
                ADDR_HOUR: alm_hour <= wdata;
                ADDR_MASK: alm_mask <= wdata[DAYS-1:0];
                ADDR_CTRL: alm_en   <= wdata[EN_BIT];
            endcase
        end
    end

    assign clr_pulse = we && (addr == ADDR_CTRL) && wdata[CLR_BIT];
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int DAYS    = 7,
    parameter int FIELD_W = 8,
    localparam int WDAY_W = $clog2(DAYS + 1)
) (
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [WDAY_W-1:0]  cur_wday,
    input  logic [FIELD_W-1:0] alm_min,
    input  logic [FIELD_W-1:0] alm_hour,
    input  logic [DAYS-1:0]    alm_mask,
    output logic               hit
);
    logic [DAYS-1:0] day_sel;

    for (genvar d = 0; d < DAYS; d++) begin : g_day
        assign day_sel[d] = alm_mask[d] && (cur_wday == WDAY_W'(d));
    end

    assign hit = (cur_min == alm_min) && (cur_hour == alm_hour) && (|day_sel);
endmodule

// File: rtl/rtc_alarm_fsm.sv
module rtc_alarm_fsm (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hit,
    input  logic                        alm_en,
    input  logic                        clr_pulse,
    output rtc_alarm_pkg::alarm_state_e st,
    output logic                        flag,
    output logic                        irq
);
    import rtc_alarm_pkg::*;

    alarm_state_e st_nxt;
    logic         fire;

    always_comb begin
        st_nxt = st;
        fire   = 1'b0;
        unique case (st)
            ST_ARMED: if (hit) begin
                st_nxt = ST_HELD;
                fire   = alm_en;
            end
            ST_HELD: if (!hit) st_nxt = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_ARMED;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag <= 1'b0;
        else if (fire)      flag <= 1'b1;
        else if (clr_pulse) flag <= 1'b0;
    end

    assign irq = flag && alm_en;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int DAYS    = 7,
    parameter int FIELD_W = 8,
    parameter int EN_BIT  = 4,
    parameter int CLR_BIT = 0,
    localparam int WDAY_W = $clog2(DAYS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [FIELD_W-1:0] cfg_wdata,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [WDAY_W-1:0]  cur_wday,
    output logic               alarm_irq
);
    logic [FIELD_W-1:0]         alm_min, alm_hour;
    logic [DAYS-1:0]            alm_mask;
    logic                       alm_en, clr_pulse, hit, flag;
    rtc_alarm_pkg::alarm_state_e st;

    rtc_alarm_regs #(.DAYS(DAYS), .FIELD_W(FIELD_W), .EN_BIT(EN_BIT), .CLR_BIT(CLR_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .alm_min(alm_min), .alm_hour(alm_hour), .alm_mask(alm_mask),
        .alm_en(alm_en), .clr_pulse(clr_pulse)
    );

    rtc_alarm_match #(.DAYS(DAYS), .FIELD_W(FIELD_W)) u_match (
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
        .alm_min(alm_min), .alm_hour(alm_hour), .alm_mask(alm_mask), .hit(hit)
    );

    rtc_alarm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .alm_en(alm_en), .clr_pulse(clr_pulse),
        .st(st), .flag(flag), .irq(alarm_irq)
    );
endmodule

// File: rtl/rtc_alarm_cmp_chk.sv
module rtc_alarm_cmp_chk #(
    parameter int FIELD_W = 8,
    parameter int CLR_BIT = 0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_we,
    input logic [1:0]                  cfg_addr,
    input logic [FIELD_W-1:0]          cfg_wdata,
    input logic                        hit,
    input logic                        alm_en,
    input rtc_alarm_pkg::alarm_state_e st,
    input logic                        flag
);
    import rtc_alarm_pkg::*;

    logic clr_wr;
    assign clr_wr = cfg_we && (cfg_addr == ADDR_CTRL) && cfg_wdata[CLR_BIT];

    // R4, R3: a new flag needs a match seen while armed
    a_r4_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(st) == ST_ARMED) && $past(hit));

    // R6: flag only rises with the enable set before the edge
    a_r6_enable_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(alm_en));

    // R8: a clear write with no new entry empties the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !(hit && st == ST_ARMED && alm_en)) |=> !flag);

    // R7: a pending flag holds until a clear write
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_wr) |=> flag);

    // R5: leaving the match re-arms
    a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HELD && !hit) |=> (st == ST_ARMED));
endmodule

bind rtc_alarm_cmp rtc_alarm_cmp_chk #(.FIELD_W(FIELD_W), .CLR_BIT(CLR_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hit(hit), .alm_en(alm_en), .st(st), .flag(flag)
);

// File: tb/rtc_alarm_cmp_tb.sv
module rtc_alarm_cmp_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cur_min = 8'h00, cur_hour = 8'h00;
    logic [2:0] cur_wday = 3'd0;
    logic       alarm_irq;
    int         n_chk = 0, n_fail = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    rtc_alarm_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday), .alarm_irq(alarm_irq)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic check(input string req, input logic exp);
        n_chk++;
        if (alarm_irq !== exp) begin
            n_fail++;
            $display("FAIL %s: alarm_irq=%b expected %b", req, alarm_irq, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] m, input logic [7:0] h, input logic [2:0] w);
        cur_min = m; cur_hour = h; cur_wday = w;
        @(negedge clk);
    endtask

    // leave the match, then clear with the enable set
    task automatic rearm();
        set_time(8'h59, 8'h23, 3'd7);
        wr(2'd3, 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 1'b0);
        set_time(8'h00, 8'h00, 3'd0);
        check("R1 no enable or mask after reset", 1'b0);

        // R3: every mask against every weekday code
        wr(2'd0, 8'h30);
        wr(2'd1, 8'h12);
        for (int m = 0; m < 128; m++) begin
            wr(2'd2, 8'(m));
            for (int w = 0; w < 8; w++) begin
                rearm();
                set_time(8'h30, 8'h12, 3'(w));
                check("R3 weekday mask", (w < 7) ? m[w] : 1'b0);
            end
        end

        // R2: minute and hour sweeps
        wr(2'd2, 8'h7F);
        for (int v = 0; v < 60; v++) begin
            rearm();
            set_time(to_bcd(v), 8'h12, 3'd2);
            check("R2 minute compare", v == 30);
        end
        for (int v = 0; v < 24; v++) begin
            rearm();
            set_time(8'h30, to_bcd(v), 3'd2);
            check("R2 hour compare", v == 12);
        end

        // R4: cleared while still matching stays low
        rearm();
        set_time(8'h30, 8'h12, 3'd1);
        check("R4 first trigger", 1'b1);
        wr(2'd3, 8'h11);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R4 no retrigger in interval", 1'b0);
        end

        // R5: leave and re-enter; entry by a register write
        set_time(8'h31, 8'h12, 3'd1);
        set_time(8'h30, 8'h12, 3'd1);
        check("R5 re-arm after leaving", 1'b1);
        rearm();
        set_time(8'h31, 8'h12, 3'd1);
        check("R5 no match before write", 1'b0);
        wr(2'd0, 8'h31);
        @(negedge clk);
        check("R5 entry by alarm write", 1'b1);
        wr(2'd0, 8'h30);

        // R6: disabled at entry, enabled later in the interval
        set_time(8'h59, 8'h23, 3'd7);
        wr(2'd3, 8'h01);
        set_time(8'h30, 8'h12, 3'd3);
        check("R6 disabled at entry", 1'b0);
        wr(2'd3, 8'h10);
        @(negedge clk);
        check("R6 late enable raises nothing", 1'b0);
        set_time(8'h31, 8'h12, 3'd3);
        set_time(8'h30, 8'h12, 3'd3);
        check("R6 enabled entry fires", 1'b1);

        // R7, R8: hide a pending flag, show it again, then clear
        wr(2'd3, 8'h00);
        check("R7 writing zero hides pending flag", 1'b0);
        wr(2'd3, 8'h10);
        check("R7 pending flag shown again", 1'b1);
        check("R8 bit0 clear keeps flag", 1'b1);
        wr(2'd3, 8'h11);
        check("R8 clear bit empties flag", 1'b0);

        // R9: clear write coincides with a new entry
        set_time(8'h59, 8'h23, 3'd7);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 8'h11;
        cur_min = 8'h30; cur_hour = 8'h12; cur_wday = 3'd4;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9 set wins over clear", 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule